// File: doc/BRIEF.md
# Queued Interrupt Dispatch Controller

This block sits beside a small 16-bit processor core and owns its interrupt flow. Software interrupt messages arrive as operations from the core and are held in a first-in first-out queue. Each time the core reaches an instruction boundary, the block checks whether dispatch is enabled and whether a message is waiting. If both hold, it stalls the core's fetch and saves the program counter and register A on a downward-growing stack. It then redirects the program counter to the interrupt-address register and hands the oldest message to register A.

The block also runs the return-from-interrupt sequence. That sequence re-enables dispatch, pops A and then pops the program counter. It also serves the operations that read and write the interrupt-address register and the one that freezes or unfreezes dispatch. The queue holds one entry more than its limit. A message that arrives while the queue is already past its limit is dropped, and a sticky overflow flag marks the fatal state. Stack traffic goes through one memory port, one access per clock, with a read latency of one cycle.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: Dispatch starts only in a cycle where the block is idle, `boundary_i` is high, dispatch is enabled, the queue is non-empty and no operation is presented. An operation presented in the same cycle wins, and dispatch waits.
- R2: In the cycle after dispatch starts, the block writes `pc_i` at address `sp_i-1`. In the next cycle it writes `a_i` at `sp_i-2`. Both values are captured in the start cycle.
- R3: In the cycle after the second write, the block asserts `pc_we_o` with `pc_o` equal to the interrupt address, `a_we_o` with `a_o` equal to the head message, and `sp_we_o` with `sp_o = sp_i-2`. It then removes that message.
- R4: Return (kind 3) enables dispatch and reads address `sp_i` in the next cycle, then `sp_i+1` in the cycle after. A is written with the first word one cycle after its read. PC is written with the second word one cycle after its read, together with `sp_o = sp_i+2`.
- R5: Queue control (kind 4) with a nonzero argument disables dispatch while messages still enqueue. A zero argument re-enables dispatch.
- R6: The queue holds Q_LIMIT+1 messages. A software interrupt (kind 0) that arrives while it is full is dropped and sets `overflow_o`, which stays set until reset.
- R7: `op_cost_o` is 0 when no operation is valid. Otherwise it is 4 for kind 0, 1 for kinds 1 and 2, 3 for kind 3 and 2 for kind 4.
- R8: Reset empties the queue, clears overflow, enables dispatch, clears the interrupt address to 0 and leaves the block idle.
- R9: Interrupt-address write (kind 2) loads `op_arg_i` into `ia_o` one cycle later. Read (kind 1) leaves it unchanged.
- R10: `busy_o` is high from the start cycle of a dispatch or return through its last cycle. Operations presented while busy (apart from the start cycle) are ignored.
- R11: Messages leave in arrival order. `head_o` shows the oldest one, and `q_empty_o`/`q_full_o` report occupancy 0 and Q_LIMIT+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| boundary_i | input | 1 | Core is at an instruction boundary, about to fetch |
| op_valid_i | input | 1 | Interrupt-related operation presented |
| op_kind_i | input | 3 | 0 swi, 1 ia read, 2 ia write, 3 return, 4 queue control |
| op_arg_i | input | 16 | Operation argument |
| pc_i | input | 16 | Core program counter |
| a_i | input | 16 | Core register A |
| sp_i | input | 16 | Core stack pointer |
| mem_rdata_i | input | 16 | Memory read data, one cycle after the read |
| busy_o | output | 1 | Stall fetch |
| op_cost_o | output | 3 | Cycle cost of the presented operation |
| mem_we_o | output | 1 | Stack write |
| mem_re_o | output | 1 | Stack read |
| mem_addr_o | output | 16 | Stack address |
| mem_wdata_o | output | 16 | Stack write data |
| pc_we_o | output | 1 | Load core PC |
| pc_o | output | 16 | New PC |
| a_we_o | output | 1 | Load core A |
| a_o | output | 16 | New A |
| sp_we_o | output | 1 | Load core SP |
| sp_o | output | 16 | New SP |
| ia_o | output | 16 | Interrupt-address register |
| head_o | output | 16 | Oldest queued message |
| q_empty_o | output | 1 | Queue empty |
| q_full_o | output | 1 | Queue holds Q_LIMIT+1 messages |
| overflow_o | output | 1 | Sticky overflow |

## Verification
The bench builds the block with W=16 and Q_LIMIT=4, so the queue fills after five messages. This puts the full flag, the dropped sixth message and the sticky overflow within a few cycles of reach. With the default limit, the bench would need hundreds of enqueues to get there. Random enqueue and dispatch mixes then cycle the read and write pointers through the odd depth of five many times. Returns that follow a dispatch read back the very words the dispatch pushed.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;

  typedef enum logic [2:0] {
    OP_SWI   = 3'd0,
    OP_IA_RD = 3'd1,
    OP_IA_WR = 3'd2,
    OP_RET   = 3'd3,
    OP_QCTL  = 3'd4
  } op_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PUSH_PC,
    S_PUSH_A,
    S_LOAD,
    S_POP_A,
    S_POP_PC,
    S_RET_WB
  } seq_state_e;

  function automatic logic [2:0] op_cost(input logic [2:0] kind);
    case (kind)
      OP_SWI:   op_cost = 3'd4;
      OP_IA_RD: op_cost = 3'd1;
      OP_IA_WR: op_cost = 3'd1;
      OP_RET:   op_cost = 3'd3;
      OP_QCTL:  op_cost = 3'd2;
      default:  op_cost = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/irq_msg_fifo.sv
module irq_msg_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 257
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         overflow_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    ptr_next = (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty_o    = (cnt_q == '0);
  assign full_o     = (cnt_q == CW'(DEPTH));
  assign do_pop     = pop_i && !empty_o;
  assign do_push    = push_i && (!full_o || do_pop);
  assign head_o     = store_q[rd_q];
  assign overflow_o = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (do_push) wr_q <= ptr_next(wr_q);
      if (do_pop)  rd_q <= ptr_next(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
      if (push_i && !do_push) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) store_q[wr_q] <= data_i;
  end

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ia_we_i,
  input  logic [W-1:0] ia_wdata_i,
  input  logic         trig_set_i,
  input  logic         trig_clr_i,
  output logic [W-1:0] ia_o,
  output logic         trig_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ia_o      <= '0;
      trig_en_o <= 1'b1;
    end else begin
      if (ia_we_i)         ia_o      <= ia_wdata_i;
      if (trig_set_i)      trig_en_o <= 1'b1;
      else if (trig_clr_i) trig_en_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_disp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         boundary_i,
  input  logic         op_valid_i,
  input  logic [2:0]   op_kind_i,
  input  logic [W-1:0] op_arg_i,
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] sp_i,
  input  logic [W-1:0] mem_rdata_i,
  input  logic         q_empty_i,
  input  logic [W-1:0] q_head_i,
  input  logic [W-1:0] ia_i,
  input  logic         trig_en_i,
  output logic         q_push_o,
  output logic         q_pop_o,
  output logic         ia_we_o,
  output logic         trig_set_o,
  output logic         trig_clr_o,
  output logic         busy_o,
  output logic         mem_we_o,
  output logic         mem_re_o,
  output logic [W-1:0] mem_addr_o,
  output logic [W-1:0] mem_wdata_o,
  output logic         pc_we_o,
  output logic [W-1:0] pc_o,
  output logic         a_we_o,
  output logic [W-1:0] a_o,
  output logic         sp_we_o,
  output logic [W-1:0] sp_o
);
  seq_state_e   state_q, state_d;
  logic [W-1:0] sp_q, sp_d, pc_q, a_q;
  logic         idle, op_go, disp_go, ret_go, qctl_go;

  assign idle    = (state_q == S_IDLE);
  assign op_go   = idle && op_valid_i;
  assign disp_go = idle && !op_valid_i && boundary_i && trig_en_i && !q_empty_i;
  assign ret_go  = op_go && (op_kind_i == OP_RET);
  assign qctl_go = op_go && (op_kind_i == OP_QCTL);

  assign busy_o     = !idle || disp_go || ret_go;
  assign q_push_o   = op_go && (op_kind_i == OP_SWI);
  assign ia_we_o    = op_go && (op_kind_i == OP_IA_WR);
  assign trig_set_o = ret_go || (qctl_go && (op_arg_i == '0));
  assign trig_clr_o = qctl_go && (op_arg_i != '0);

  always_comb begin
    state_d     = state_q;
    sp_d        = sp_q;
    q_pop_o     = 1'b0;
    mem_we_o    = 1'b0;
    mem_re_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    pc_we_o     = 1'b0;
    pc_o        = '0;
    a_we_o      = 1'b0;
    a_o         = '0;
    sp_we_o     = 1'b0;
    sp_o        = '0;
    case (state_q)
      S_IDLE: begin
        if (disp_go) begin
          state_d = S_PUSH_PC;
          sp_d    = sp_i;
        end else if (ret_go) begin
          state_d = S_POP_A;
          sp_d    = sp_i;
        end
      end
      S_PUSH_PC: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_q - W'(1);
        mem_wdata_o = pc_q;
        sp_d        = sp_q - W'(1);
        state_d     = S_PUSH_A;
      end
      S_PUSH_A: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_q - W'(1);
        mem_wdata_o = a_q;
        sp_d        = sp_q - W'(1);
        state_d     = S_LOAD;
      end
      S_LOAD: begin
        pc_we_o = 1'b1;
        pc_o    = ia_i;
        a_we_o  = 1'b1;
        a_o     = q_head_i;
        sp_we_o = 1'b1;
        sp_o    = sp_q;
        q_pop_o = 1'b1;
        state_d = S_IDLE;
      end
      S_POP_A: begin
        mem_re_o   = 1'b1;
        mem_addr_o = sp_q;
        sp_d       = sp_q + W'(1);
        state_d    = S_POP_PC;
      end
      S_POP_PC: begin
        mem_re_o   = 1'b1;
        mem_addr_o = sp_q;
        sp_d       = sp_q + W'(1);
        a_we_o     = 1'b1;
        a_o        = mem_rdata_i;
        state_d    = S_RET_WB;
      end
      S_RET_WB: begin
        pc_we_o = 1'b1;
        pc_o    = mem_rdata_i;
        sp_we_o = 1'b1;
        sp_o    = sp_q;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      sp_q    <= '0;
      pc_q    <= '0;
      a_q     <= '0;
    end else begin
      state_q <= state_d;
      sp_q    <= sp_d;
      if (disp_go) begin
        pc_q <= pc_i;
        a_q  <= a_i;
      end
    end
  end

endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl
  import irq_disp_pkg::*;
#(
  parameter int W       = 16,
  parameter int Q_LIMIT = 256
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         boundary_i,
  input  logic         op_valid_i,
  input  logic [2:0]   op_kind_i,
  input  logic [W-1:0] op_arg_i,
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] sp_i,
  input  logic [W-1:0] mem_rdata_i,
  output logic         busy_o,
  output logic [2:0]   op_cost_o,
  output logic         mem_we_o,
  output logic         mem_re_o,
  output logic [W-1:0] mem_addr_o,
  output logic [W-1:0] mem_wdata_o,
  output logic         pc_we_o,
  output logic [W-1:0] pc_o,
  output logic         a_we_o,
  output logic [W-1:0] a_o,
  output logic         sp_we_o,
  output logic [W-1:0] sp_o,
  output logic [W-1:0] ia_o,
  output logic [W-1:0] head_o,
  output logic         q_empty_o,
  output logic         q_full_o,
  output logic         overflow_o
);
  localparam int DEPTH = Q_LIMIT + 1;

  logic q_push, q_pop, ia_we, trig_set, trig_clr, trig_en;

  assign op_cost_o = op_valid_i ? op_cost(op_kind_i) : 3'd0;

  irq_msg_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (q_push),
    .data_i     (op_arg_i),
    .pop_i      (q_pop),
    .head_o     (head_o),
    .empty_o    (q_empty_o),
    .full_o     (q_full_o),
    .overflow_o (overflow_o)
  );

  irq_cfg_regs #(.W(W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ia_we_i    (ia_we),
    .ia_wdata_i (op_arg_i),
    .trig_set_i (trig_set),
    .trig_clr_i (trig_clr),
    .ia_o       (ia_o),
    .trig_en_o  (trig_en)
  );

  irq_seq #(.W(W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .boundary_i  (boundary_i),
    .op_valid_i  (op_valid_i),
    .op_kind_i   (op_kind_i),
    .op_arg_i    (op_arg_i),
    .pc_i        (pc_i),
    .a_i         (a_i),
    .sp_i        (sp_i),
    .mem_rdata_i (mem_rdata_i),
    .q_empty_i   (q_empty_o),
    .q_head_i    (head_o),
    .ia_i        (ia_o),
    .trig_en_i   (trig_en),
    .q_push_o    (q_push),
    .q_pop_o     (q_pop),
    .ia_we_o     (ia_we),
    .trig_set_o  (trig_set),
    .trig_clr_o  (trig_clr),
    .busy_o      (busy_o),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .pc_we_o     (pc_we_o),
    .pc_o        (pc_o),
    .a_we_o      (a_we_o),
    .a_o         (a_o),
    .sp_we_o     (sp_we_o),
    .sp_o        (sp_o)
  );

endmodule

// File: rtl/irq_dispatch_ctrl_chk.sv
module irq_dispatch_ctrl_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         boundary_i,
  input logic         op_valid_i,
  input logic         busy_o,
  input logic         mem_we_o,
  input logic         mem_re_o,
  input logic [W-1:0] mem_addr_o,
  input logic         pc_we_o,
  input logic         a_we_o,
  input logic         sp_we_o,
  input logic         q_empty_o,
  input logic         q_full_o,
  input logic         overflow_o
);
  p_first_push_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !$past(mem_we_o)) |-> ($past(boundary_i) && !$past(q_empty_o) && !$past(op_valid_i)));

  p_push_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) - W'(1)));

  p_load_after_push_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_we_o && !$past(mem_re_o)) |-> ($past(mem_we_o) && a_we_o && sp_we_o));

  p_pop_up_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && $past(mem_re_o)) |-> (mem_addr_o == $past(mem_addr_o) + W'(1)));

  p_overflow_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  p_busy_cover_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o || pc_we_o || a_we_o) |-> busy_o);

  p_one_access_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  p_full_not_empty_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_full_o |-> !q_empty_o);
endmodule

bind irq_dispatch_ctrl irq_dispatch_ctrl_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .boundary_i (boundary_i),
  .op_valid_i (op_valid_i),
  .busy_o     (busy_o),
  .mem_we_o   (mem_we_o),
  .mem_re_o   (mem_re_o),
  .mem_addr_o (mem_addr_o),
  .pc_we_o    (pc_we_o),
  .a_we_o     (a_we_o),
  .sp_we_o    (sp_we_o),
  .q_empty_o  (q_empty_o),
  .q_full_o   (q_full_o),
  .overflow_o (overflow_o)
);

// File: tb/irq_dispatch_ctrl_tb.sv
module irq_dispatch_ctrl_tb;
  localparam int W     = 16;
  localparam int QL    = 4;
  localparam int DEPTH = QL + 1;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         boundary_i = 1'b0, op_valid_i = 1'b0;
  logic [2:0]   op_kind_i = '0;
  logic [W-1:0] op_arg_i = '0, pc_i = '0, a_i = '0, sp_i = '0, mem_rdata_i = '0;
  logic         busy_o, mem_we_o, mem_re_o, pc_we_o, a_we_o, sp_we_o;
  logic [2:0]   op_cost_o;
  logic [W-1:0] mem_addr_o, mem_wdata_o, pc_o, a_o, sp_o, ia_o, head_o;
  logic         q_empty_o, q_full_o, overflow_o;

  int n_tests = 0, n_fail = 0;
  logic [W-1:0] bmem [256];
  logic [W-1:0] mq [$];
  logic [W-1:0] ia_m = '0;
  logic         done = 1'b0;

  always #4 clk = ~clk;

  irq_dispatch_ctrl #(.W(W), .Q_LIMIT(QL)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .boundary_i(boundary_i), .op_valid_i(op_valid_i),
    .op_kind_i(op_kind_i), .op_arg_i(op_arg_i), .pc_i(pc_i), .a_i(a_i), .sp_i(sp_i),
    .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .op_cost_o(op_cost_o),
    .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .pc_we_o(pc_we_o), .pc_o(pc_o), .a_we_o(a_we_o),
    .a_o(a_o), .sp_we_o(sp_we_o), .sp_o(sp_o), .ia_o(ia_o), .head_o(head_o),
    .q_empty_o(q_empty_o), .q_full_o(q_full_o), .overflow_o(overflow_o)
  );

  always @(posedge clk) begin
    if (mem_we_o) bmem[mem_addr_o[7:0]] <= mem_wdata_o;
    if (mem_re_o) mem_rdata_i <= bmem[mem_addr_o[7:0]];
  end

  function automatic logic [2:0] exp_cost(input logic [2:0] k);
    case (k)
      3'd0: return 3'd4;
      3'd1, 3'd2: return 3'd1;
      3'd3: return 3'd3;
      3'd4: return 3'd2;
      default: return 3'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_op(input logic [2:0] kind, input logic [W-1:0] arg);
    op_valid_i = 1'b1; op_kind_i = kind; op_arg_i = arg;
    #1 chk("R7 op cost", op_cost_o, exp_cost(kind));
    @(negedge clk);
    op_valid_i = 1'b0;
    if (kind == 3'd0) begin
      if (mq.size() < DEPTH) mq.push_back(arg);
    end else if (kind == 3'd2) ia_m = arg;
  endtask

  task automatic dispatch(input logic [W-1:0] pc, input logic [W-1:0] a,
                          input logic [W-1:0] sp, input bit inject);
    logic [W-1:0] msg;
    msg = mq.pop_front();
    chk("R11 head before dispatch", head_o, msg);
    boundary_i = 1'b1; pc_i = pc; a_i = a; sp_i = sp;
    #1 chk("R10 busy at start", busy_o, 1);
    @(negedge clk);
    boundary_i = 1'b0; pc_i = '0; a_i = '0; sp_i = '0;
    if (inject) begin op_valid_i = 1'b1; op_kind_i = 3'd0; op_arg_i = 16'hBEEF; end
    #1 chk("R2 push pc we", {mem_we_o, mem_re_o}, 2'b10);
    chk("R2 push pc addr", mem_addr_o, sp - 16'd1);
    chk("R2 push pc data", mem_wdata_o, pc);
    @(negedge clk);
    op_valid_i = 1'b0;
    #1 chk("R2 push a we", mem_we_o, 1);
    chk("R2 push a addr", mem_addr_o, sp - 16'd2);
    chk("R2 push a data", mem_wdata_o, a);
    @(negedge clk);
    #1 chk("R3 load strobes", {pc_we_o, a_we_o, sp_we_o, mem_we_o}, 4'b1110);
    chk("R3 pc from ia", pc_o, ia_m);
    chk("R3 a gets message", a_o, msg);
    chk("R3 sp after pushes", sp_o, sp - 16'd2);
    @(negedge clk);
    #1 chk("R10 idle after dispatch", busy_o, 0);
  endtask

  task automatic do_ret(input logic [W-1:0] sp, input logic [W-1:0] ea, input logic [W-1:0] epc);
    op_valid_i = 1'b1; op_kind_i = 3'd3; op_arg_i = '0; sp_i = sp;
    #1 chk("R7 ret cost", op_cost_o, 3'd3);
    chk("R10 busy at ret start", busy_o, 1);
    @(negedge clk);
    op_valid_i = 1'b0; sp_i = '0;
    #1 chk("R4 pop a read", {mem_re_o, mem_we_o}, 2'b10);
    chk("R4 pop a addr", mem_addr_o, sp);
    @(negedge clk);
    #1 chk("R4 pop pc addr", mem_addr_o, sp + 16'd1);
    chk("R4 a write", {a_we_o, mem_re_o}, 2'b11);
    chk("R4 a value", a_o, ea);
    @(negedge clk);
    #1 chk("R4 pc write", {pc_we_o, sp_we_o, a_we_o}, 3'b110);
    chk("R4 pc value", pc_o, epc);
    chk("R4 sp value", sp_o, sp + 16'd2);
    @(negedge clk);
  endtask

  task automatic expect_no_dispatch(input string req);
    boundary_i = 1'b1; pc_i = 16'h0100; sp_i = 16'h0040;
    #1 chk(req, busy_o, 0);
    @(negedge clk);
    boundary_i = 1'b0;
    #1 chk(req, mem_we_o, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] sd;
    sd = $urandom(32'h00C0FFEE);
    repeat (3) @(negedge clk);
    chk("R8 reset empty", {q_empty_o, q_full_o, overflow_o, busy_o}, 4'b1000);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R8 ia cleared", ia_o, 0);
    chk("R7 no op cost", op_cost_o, 0);

    send_op(3'd2, 16'h1234);
    chk("R9 ia write", ia_o, 16'h1234);
    send_op(3'd1, 16'h0000);
    chk("R9 ia read no change", ia_o, 16'h1234);

    expect_no_dispatch("R1 empty queue no dispatch");

    send_op(3'd0, 16'h0011);
    send_op(3'd0, 16'h0022);
    send_op(3'd0, 16'h0033);
    chk("R11 head oldest", head_o, 16'h0011);
    chk("R11 not empty", q_empty_o, 0);

    // op beats dispatch in same cycle
    boundary_i = 1'b1; op_valid_i = 1'b1; op_kind_i = 3'd1; op_arg_i = '0;
    #1 chk("R1 op takes precedence", busy_o, 0);
    @(negedge clk);
    op_valid_i = 1'b0; boundary_i = 1'b0;
    #1 chk("R1 no push after op", mem_we_o, 0);

    dispatch(16'h0200, 16'hAAAA, 16'h0080, 1'b0);
    do_ret(16'h007E, 16'hAAAA, 16'h0200);
    dispatch(16'h0310, 16'h5555, 16'h0060, 1'b0);
    dispatch(16'h0420, 16'h0F0F, 16'h005E, 1'b0);
    do_ret(16'h005C, 16'h0F0F, 16'h0420);
    do_ret(16'h005E, 16'h5555, 16'h0310);
    chk("R11 empty after drain", q_empty_o, 1);

    // freeze and unfreeze
    send_op(3'd4, 16'h0007);
    send_op(3'd0, 16'h0044);
    expect_no_dispatch("R5 frozen no dispatch");
    chk("R5 message still queued", head_o, 16'h0044);
    send_op(3'd4, 16'h0000);
    dispatch(16'h0500, 16'h1111, 16'h00A0, 1'b0);

    // return re-enables
    send_op(3'd4, 16'h0001);
    send_op(3'd0, 16'h0055);
    expect_no_dispatch("R5 frozen again");
    do_ret(16'h009E, 16'h1111, 16'h0500);
    dispatch(16'h0600, 16'h2222, 16'h00B0, 1'b0);

    // op while busy ignored
    send_op(3'd0, 16'h0066);
    dispatch(16'h0700, 16'h3333, 16'h00C0, 1'b1);
    chk("R10 op while busy ignored", q_empty_o, 1);

    // fill and overflow
    for (int k = 0; k < DEPTH; k++) send_op(3'd0, 16'h0100 + 16'(k));
    chk("R11 full at limit+1", {q_full_o, overflow_o}, 2'b10);
    send_op(3'd0, 16'hDEAD);
    chk("R6 overflow set", {q_full_o, overflow_o}, 2'b11);
    for (int k = 0; k < DEPTH; k++) dispatch(16'h0800 + 16'(k), 16'(k), 16'h0090, 1'b0);
    chk("R6 dropped message absent", q_empty_o, 1);
    chk("R6 overflow sticky", overflow_o, 1);

    // random mix
    for (int it = 0; it < 120; it++) begin
      int r;
      r = $urandom_range(0, 3);
      if (r == 0 && mq.size() < DEPTH) begin
        send_op(3'd0, 16'($urandom));
      end else if (r == 1) begin
        send_op(3'd2, 16'($urandom));
        chk("R9 random ia write", ia_o, ia_m);
      end else if (mq.size() > 0) begin
        logic [W-1:0] rp, ra, rs;
        rp = 16'($urandom); ra = 16'($urandom);
        rs = 16'($urandom_range(16, 240));
        dispatch(rp, ra, rs, 1'b0);
        if ($urandom_range(0, 1) == 1) do_ret(rs - 16'd2, ra, rp);
      end else begin
        send_op(3'd0, 16'($urandom));
      end
    end

    // reset mid-run
    send_op(3'd0, 16'h0077);
    rst_ni = 1'b0;
    #1 chk("R8 reset clears queue", {q_empty_o, overflow_o, busy_o}, 3'b100);
    @(negedge clk);
    rst_ni = 1'b1;
    mq.delete(); ia_m = '0;
    @(negedge clk);
    chk("R8 ia after reset", ia_o, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule